// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits between a converter's sample path and its parallel output bus. In normal operation it forwards each sample to the bus. When a test code is programmed, it replaces the samples with a known word instead. The word is either a fixed preset (midscale, either full-scale rail, checkerboard, one/zero) or one of two words that software assembles from byte registers. The word can be held steady, or the bus can alternate between a first and a second word on every sample clock. This lets board-level tests confirm every data line without a live analog input.

Software programs a control byte and four user-pattern bytes through a simple register write port that runs on its own clock. The settings reach the sample-clock domain through a synchronizer chain. A new setting therefore shows up on the bus a fixed, small number of sample clocks after the write.

Top module: `adc_testpat_gen`

## Requirements
- R1: After reset the output bus is 0, and all settings are zero, so the block is in pass-through mode.
- R2: With pattern code 0 (control bits [3:0] = 0000), the output is the sample input, registered once (one sample-clock latency).
- R3: Codes 0001, 0010 and 0011 drive the top 12 bits of 0x8000, 0xFFFF and 0x0000 (0x800, 0xFFF, 0x000) on every cycle.
- R4: Code 0100 with alternate selected (control bits [7:6] = 01) drives 0xAAA and 0x555 on successive cycles, starting with 0xAAA.
- R5: Code 0111 with alternate selected drives 0xFFF and 0x000 on successive cycles, starting with 0xFFF.
- R6: Code 1000 uses user word 1, built as {byte at 0xC3, byte at 0xC2}, and user word 2, built as {byte at 0xC5, byte at 0xC4}. The bus carries bits [15:4] of the selected word.
- R7: Control bits [7:6] = 00 (static) hold word 1 on every cycle. The reserved values 10 and 11 act as static.
- R8: The single-word presets (codes 0001 to 0011) drive word 1 in both phases, even when alternate is selected.
- R9: The reserved codes 0101, 0110 and 1001 to 1111 act as code 0 (pass-through).
- R10: A register write takes effect on the bus at the third sample-clock edge after the edge that stores it (two synchronizer flops plus the output register). The bus keeps its previous behaviour before that edge.
- R11: When the effective mode (code, or static/alternate selection) changes, the first output under the new mode is word 1. A change to the user bytes alone does not restart the phase.
- R12: Writes to any address other than 0xC0, 0xC2, 0xC3, 0xC4 and 0xC5 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-port clock |
| reg_rst | input | 1 | Synchronous active-high reset, register domain |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | 8 | Write address |
| reg_wdata | input | 8 | Write data byte |
| smp_clk | input | 1 | Sample clock |
| smp_rst | input | 1 | Synchronous active-high reset, sample domain |
| smp_din | input | 12 | Converter sample input |
| smp_dout | output | 12 | Output data bus |

## Verification
The bench builds the block with its default parameters: a two-flop synchronizer and the standard register addresses. Both clock ports are driven from one clock. This makes the three-edge delay from a write to the bus an exact cycle count that the reference model can check on every clock. In that setup, back-to-back writes to the control byte bring the phase restart on every mode change within reach. Changing user bytes while the bus alternates shows that the phase is not restarted by data-only changes.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int TP_PAT_W  = 16;
    localparam int TP_OUT_W  = 12;
    localparam int TP_CODE_W = 4;

    localparam logic [TP_CODE_W-1:0] CODE_OFF  = 4'h0;
    localparam logic [TP_CODE_W-1:0] CODE_MID  = 4'h1;
    localparam logic [TP_CODE_W-1:0] CODE_POS  = 4'h2;
    localparam logic [TP_CODE_W-1:0] CODE_NEG  = 4'h3;
    localparam logic [TP_CODE_W-1:0] CODE_CHK  = 4'h4;
    localparam logic [TP_CODE_W-1:0] CODE_ONEZ = 4'h7;
    localparam logic [TP_CODE_W-1:0] CODE_USER = 4'h8;

    localparam logic [1:0] SEL_ALT = 2'b01;

    typedef struct packed {
        logic [1:0]           alt_sel;
        logic [TP_CODE_W-1:0] code;
        logic [TP_OUT_W-1:0]  user1;
        logic [TP_OUT_W-1:0]  user2;
    } tp_cfg_t;

    typedef struct packed {
        logic [TP_CODE_W-1:0] code;
        logic                 alt;
    } tp_mode_t;

    typedef struct packed {
        logic                active;
        logic                has2;
        logic [TP_OUT_W-1:0] w1;
        logic [TP_OUT_W-1:0] w2;
    } tp_pat_t;

    function automatic logic [TP_OUT_W-1:0] tp_top(input logic [TP_PAT_W-1:0] w);
        return w[TP_PAT_W-1 -: TP_OUT_W];
    endfunction

    function automatic tp_mode_t tp_decode(input tp_cfg_t c);
        tp_mode_t m;
        m.code = c.code;
        m.alt  = (c.alt_sel == SEL_ALT);
        return m;
    endfunction

    function automatic tp_pat_t tp_lookup(input logic [TP_CODE_W-1:0] code,
                                          input logic [TP_OUT_W-1:0] u1,
                                          input logic [TP_OUT_W-1:0] u2);
        tp_pat_t p;
        p = '0;
        case (code)
            CODE_MID:  begin p.active = 1'b1; p.w1 = tp_top(16'h8000); end
            CODE_POS:  begin p.active = 1'b1; p.w1 = tp_top(16'hFFFF); end
            CODE_NEG:  begin p.active = 1'b1; p.w1 = tp_top(16'h0000); end
            CODE_CHK:  begin
                p.active = 1'b1; p.has2 = 1'b1;
                p.w1 = tp_top(16'hAAAA); p.w2 = tp_top(16'h5555);
            end
            CODE_ONEZ: begin
                p.active = 1'b1; p.has2 = 1'b1;
                p.w1 = tp_top(16'hFFFF); p.w2 = tp_top(16'h0000);
            end
            CODE_USER: begin
                p.active = 1'b1; p.has2 = 1'b1;
                p.w1 = u1; p.w2 = u2;
            end
            default:   p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  A_CTRL    = 8'hC0,
    parameter logic [7:0]  A_U1_LO   = 8'hC2,
    parameter logic [7:0]  A_U1_HI   = 8'hC3,
    parameter logic [7:0]  A_U2_LO   = 8'hC4,
    parameter logic [7:0]  A_U2_HI   = 8'hC5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output tp_cfg_t           cfg
);
    localparam int LO_KEEP = TP_OUT_W - 8;

    logic hit;
    assign hit = (addr == A_CTRL) || (addr == A_U1_LO) || (addr == A_U1_HI) ||
                 (addr == A_U2_LO) || (addr == A_U2_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                A_CTRL:  begin cfg.alt_sel <= wdata[7:6]; cfg.code <= wdata[3:0]; end
                A_U1_LO: cfg.user1[LO_KEEP-1:0]     <= wdata[7 -: LO_KEEP];
                A_U1_HI: cfg.user1[TP_OUT_W-1 -: 8] <= wdata;
                A_U2_LO: cfg.user2[LO_KEEP-1:0]     <= wdata[7 -: LO_KEEP];
                A_U2_HI: cfg.user2[TP_OUT_W-1 -: 8] <= wdata;
                default: ;
            endcase
        end
    end

    // R12
    unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !hit) |=> $stable(cfg));

endmodule

// File: rtl/tpg_sync.sv
module tpg_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= din;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign dout = st[STAGES-1];

endmodule

// File: rtl/tpg_core.sv
module tpg_core
    import tpg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  tp_cfg_t             cfg,
    input  logic [TP_OUT_W-1:0] din,
    output logic [TP_OUT_W-1:0] dout
);
    tp_mode_t mode, prev_mode;
    tp_pat_t  pat;
    logic     phase, eff_phase, changed, pick_w2;
    logic [TP_OUT_W-1:0] word;

    always_comb begin
        mode      = tp_decode(cfg);
        pat       = tp_lookup(mode.code, cfg.user1, cfg.user2);
        changed   = (mode != prev_mode);
        eff_phase = changed ? 1'b0 : phase;
        pick_w2   = mode.alt && pat.has2 && eff_phase;
        word      = pick_w2 ? pat.w2 : pat.w1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_mode <= '0;
            phase     <= 1'b0;
            dout      <= '0;
        end else begin
            prev_mode <= mode;
            phase     <= ~eff_phase;
            dout      <= pat.active ? word : din;
        end
    end

    // R9
    inactive_passthrough_chk: assert property (@(posedge clk) disable iff (rst)
        !pat.active |=> dout == $past(din));

    // R8
    single_word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pat.active && !pat.has2) |=> dout == $past(pat.w1));

    // R11
    restart_word1_chk: assert property (@(posedge clk) disable iff (rst)
        (changed && pat.active) |=> dout == $past(pat.w1));

    // R3
    pattern_only_chk: assert property (@(posedge clk) disable iff (rst)
        pat.active |=> (dout == $past(pat.w1)) || (dout == $past(pat.w2)));

endmodule

// File: rtl/adc_testpat_gen.sv
module adc_testpat_gen
    import tpg_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] A_CTRL      = 8'hC0,
    parameter logic [7:0] A_U1_LO     = 8'hC2,
    parameter logic [7:0] A_U1_HI     = 8'hC3,
    parameter logic [7:0] A_U2_LO     = 8'hC4,
    parameter logic [7:0] A_U2_HI     = 8'hC5
) (
    input  logic                reg_clk,
    input  logic                reg_rst,
    input  logic                reg_we,
    input  logic [7:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic                smp_clk,
    input  logic                smp_rst,
    input  logic [TP_OUT_W-1:0] smp_din,
    output logic [TP_OUT_W-1:0] smp_dout
);
    localparam int CFG_W = $bits(tp_cfg_t);

    tp_cfg_t cfg_reg, cfg_smp;
    logic [CFG_W-1:0] cfg_sync;

    tpg_regs #(
        .ADDR_W(8), .A_CTRL(A_CTRL), .A_U1_LO(A_U1_LO), .A_U1_HI(A_U1_HI),
        .A_U2_LO(A_U2_LO), .A_U2_HI(A_U2_HI)
    ) i_regs (
        .clk(reg_clk), .rst(reg_rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .cfg(cfg_reg)
    );

    tpg_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(smp_clk), .rst(smp_rst), .din(cfg_reg), .dout(cfg_sync)
    );

    assign cfg_smp = tp_cfg_t'(cfg_sync);

    tpg_core i_core (
        .clk(smp_clk), .rst(smp_rst), .cfg(cfg_smp), .din(smp_din), .dout(smp_dout)
    );

endmodule

// File: tb/test_adc_testpat_gen.sv
`timescale 1ns/1ps
module test_adc_testpat_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [11:0] din = '0;
    logic [11:0] dout;

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    adc_testpat_gen i_adc_testpat_gen (
        .reg_clk(clk), .reg_rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .smp_clk(clk), .smp_rst(rst), .smp_din(din), .smp_dout(dout)
    );

    // reference model state
    logic [7:0]  m_ctrl;
    logic [15:0] m_u1, m_u2;
    logic [39:0] q[$];
    logic [4:0]  m_prev;
    bit          m_phase;
    logic [11:0] exp_out = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_u1 = 0; m_u2 = 0; q.delete();
            m_prev = 0; m_phase = 0; exp_out = 0;
        end else begin
            logic [39:0] use_cfg;
            logic [7:0]  c;
            logic [15:0] w1, w2, sel;
            bit          act, two, alt, chg, ph;
            logic [4:0]  mode;
            q.push_back({m_ctrl, m_u1, m_u2});
            if (q.size() > 3) void'(q.pop_front());
            use_cfg = (q.size() == 3) ? q[0] : 40'h0;
            c = use_cfg[39:32];
            act = 1; two = 0; w1 = 0; w2 = 0;
            case (c[3:0])
                4'd1: w1 = 16'h8000;
                4'd2: w1 = 16'hFFFF;
                4'd3: w1 = 16'h0000;
                4'd4: begin w1 = 16'hAAAA; w2 = 16'h5555; two = 1; end
                4'd7: begin w1 = 16'hFFFF; w2 = 16'h0000; two = 1; end
                4'd8: begin w1 = use_cfg[31:16]; w2 = use_cfg[15:0]; two = 1; end
                default: act = 0;
            endcase
            alt  = (c[7:6] == 2'b01);
            mode = {c[3:0], alt};
            chg  = (mode != m_prev);
            ph   = chg ? 1'b0 : m_phase;
            sel  = (alt && two && ph) ? w2 : w1;
            exp_out = act ? sel[15:4] : din;
            m_phase = !ph;
            m_prev  = mode;
            if (we) begin
                case (addr)
                    8'hC0: m_ctrl = wdata;
                    8'hC2: m_u1[7:0]  = wdata;
                    8'hC3: m_u1[15:8] = wdata;
                    8'hC4: m_u2[7:0]  = wdata;
                    8'hC5: m_u2[15:8] = wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (dout !== exp_out) begin
                fails++;
                $display("FAIL %s: dout=%h expected=%h at %0t", cur_req, dout, exp_out, $time);
            end
        end
    end

    // sample stimulus
    always @(negedge clk) din <= din + 12'd37;

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        idle(3);
        @(negedge clk);
        checks++;
        if (dout !== 12'h000) begin
            fails++;
            $display("FAIL R1: dout=%h expected=000 in reset", dout);
        end
        rst = 1'b0;
        cur_req = "R2";          idle(6);
        cur_req = "R10";         wr(8'hC0, 8'h02); idle(5);
        cur_req = "R3";          wr(8'hC0, 8'h01); idle(6);
                                 wr(8'hC0, 8'h03); idle(6);
        cur_req = "R8";          wr(8'hC0, 8'h42); idle(6);
                                 wr(8'hC0, 8'h41); idle(6);
        cur_req = "R4";          wr(8'hC0, 8'h44); idle(8);
        cur_req = "R7";          wr(8'hC0, 8'h04); idle(5);
                                 wr(8'hC0, 8'h84); idle(5);
                                 wr(8'hC0, 8'hC4); idle(5);
        cur_req = "R5";          wr(8'hC0, 8'h47); idle(8);
        cur_req = "R11";         wr(8'hC0, 8'h44); wr(8'hC0, 8'h47); idle(3);
                                 wr(8'hC0, 8'h07); wr(8'hC0, 8'h47); idle(8);
        cur_req = "R6";          wr(8'hC2, 8'h34); wr(8'hC3, 8'h12);
                                 wr(8'hC4, 8'hCD); wr(8'hC5, 8'hAB);
                                 wr(8'hC0, 8'h48); idle(8);
                                 wr(8'hC3, 8'h9E); wr(8'hC4, 8'h5F); idle(8);
        cur_req = "R9";          wr(8'hC0, 8'h45); idle(6);
                                 wr(8'hC0, 8'h46); idle(6);
                                 wr(8'hC0, 8'h4F); idle(6);
        cur_req = "R12";         wr(8'hC0, 8'h48); idle(5);
                                 wr(8'hC1, 8'h00); wr(8'hC6, 8'hFF);
                                 wr(8'h40, 8'h02); idle(8);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule